// File: doc/BRIEF.md
# Linear Search Accelerator

This block is a bus-attached search engine. Software programs a base address, a key and an element count into its registers, then writes a launch command. The engine then walks memory by itself, one word per step. It starts at the base address and moves toward higher addresses, and it compares every word it fetches against the key.

The engine stops at the first word that equals the key and records that word's address. If it scans all the words without a hit, it records the fixed code 0xFF instead. Software polls a status word to learn whether the engine is still scanning or has finished, and then reads the result.

Memory is reached through a single synchronous read port. Data comes back one cycle after the request, and only one read is outstanding at any time. The register interface is a plain write strobe with an address and write data, plus a combinational read-data output.

Top module: `lsearch_accel`

## Requirements
- R1: After reset every register offset reads zero, `mem_req_o` is low, and status reads 0 (not busy, not done).
- R2: The base address (offset 0x0), key (offset 0x4) and element count (offset 0x8) read back the last value written, truncated to their widths. The control offset 0xC reads zero.
- R3: Writing a word with bit 0 set to offset 0xC while idle launches a search. Status bit 0 (busy) reads 1 from the next cycle onward, and status bit 1 (done) reads 0.
- R4: A search issues one single-cycle read per element, on every other cycle. The read addresses are base, base+1, base+2 and so on, in ascending order.
- R5: On a hit at element i (counting from 0), the result register at offset 0x14 holds the address of the lowest matching element. Done first reads 1 after clock edge 2i+3, counting the launch edge as edge 0.
- R6: With N elements and no hit, the result reads 0xFF after the scan, and done first reads 1 after edge 2N+1. No read is issued beyond base+N-1.
- R7: A launch with element count 0 issues no memory read. It sets done after edge 1, with result 0xFF.
- R8: A launch command written while busy is ignored. The running search finishes with its own result and timing, and no second search follows it.
- R9: Done stays set until the next accepted launch and clears on the cycle that launch is accepted. Busy and done are never both set.
- R10: The base, key and count are captured at launch. Register writes made during a search do not change its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the request |

## Verification
A stuck or mis-stepped address counter shows up at the memory port within one element time, two cycles. It appears either as a read address that is not the previous one plus one, or as a hit reported at the wrong address. A miscounted remaining-element counter moves the cycle in which done rises: the scan stops early, which also gives a wrong fail result, or it runs on and issues a read past the last element. A control state that fails to return to idle shows at once as busy and done both set, as a launch that does nothing, or as a done flag that drops without a launch.

// File: rtl/lsearch_pkg.sv
package lsearch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_COMPARE, ST_DONE} state_e;

  localparam int unsigned REG_AW = 5;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_BASE = 5'h00;
  localparam logic [REG_AW-1:0] OFF_KEY  = 5'h04;
  localparam logic [REG_AW-1:0] OFF_CNT  = 5'h08;
  localparam logic [REG_AW-1:0] OFF_CTRL = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_STAT = 5'h10;
  localparam logic [REG_AW-1:0] OFF_RES  = 5'h14;

  localparam int unsigned FAIL_VALUE = 255;
endpackage

// File: rtl/lsearch_regs.sv
module lsearch_regs
  import lsearch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] result_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [DATA_W-1:0] key_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              go_o,
  output logic [REG_DW-1:0] rdata_o
);
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] key_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      key_q  <= '0;
      cnt_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_BASE: base_q <= wdata_i[ADDR_W-1:0];
        OFF_KEY:  key_q  <= wdata_i[DATA_W-1:0];
        OFF_CNT:  cnt_q  <= wdata_i[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  // launch request; the FSM decides whether it is accepted
  assign go_o = we_i && (addr_i == OFF_CTRL) && wdata_i[0];

  always_comb begin
    case (addr_i)
      OFF_BASE: rdata_o = REG_DW'(base_q);
      OFF_KEY:  rdata_o = REG_DW'(key_q);
      OFF_CNT:  rdata_o = REG_DW'(cnt_q);
      OFF_STAT: rdata_o = REG_DW'({done_i, busy_i});
      OFF_RES:  rdata_o = REG_DW'(result_i);
      default:  rdata_o = '0;
    endcase
  end

  assign base_o = base_q;
  assign key_o  = key_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lsearch_cmp.sv
module lsearch_cmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              match_o
);
  logic [DATA_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (load_i) key_q <= key_i;
  end

  assign match_o = (data_i == key_q);
endmodule

// File: rtl/lsearch_fsm.sv
module lsearch_fsm
  import lsearch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_i,
  output logic              accept_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] result_o
);
  localparam logic [ADDR_W-1:0] FAIL_CODE = ADDR_W'(FAIL_VALUE);

  state_e            state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [CNT_W-1:0]  left_q;
  logic              done_q;
  logic [ADDR_W-1:0] res_q;

  assign accept_o = go_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            done_q <= 1'b0;
            if (cnt_i == '0) begin
              res_q   <= FAIL_CODE;
              state_q <= ST_DONE;
            end else begin
              cur_q   <= base_i;
              left_q  <= cnt_i;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: state_q <= ST_COMPARE;
        ST_COMPARE: begin
          if (match_i) begin
            res_q   <= cur_q;
            state_q <= ST_DONE;
          end else if (left_q == CNT_W'(1)) begin
            res_q   <= FAIL_CODE;
            state_q <= ST_DONE;
          end else begin
            cur_q   <= cur_q + 1'b1;
            left_q  <= left_q - 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_READ);
  assign mem_addr_o = cur_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign result_o   = res_q;
endmodule

// File: rtl/lsearch_accel.sv
module lsearch_accel
  import lsearch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] base_w;
  logic [DATA_W-1:0] key_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              go_w;
  logic              accept_w;
  logic              match_w;
  logic              busy_w;
  logic              done_w;
  logic [ADDR_W-1:0] result_w;

  lsearch_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .busy_i   (busy_w),
    .done_i   (done_w),
    .result_i (result_w),
    .base_o   (base_w),
    .key_o    (key_w),
    .cnt_o    (cnt_w),
    .go_o     (go_w),
    .rdata_o  (reg_rdata_o)
  );

  lsearch_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept_w),
    .key_i   (key_w),
    .data_i  (mem_rdata_i),
    .match_o (match_w)
  );

  lsearch_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_w),
    .base_i     (base_w),
    .cnt_i      (cnt_w),
    .match_i    (match_w),
    .accept_o   (accept_w),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_w),
    .done_o     (done_w),
    .result_o   (result_w)
  );
endmodule

// File: rtl/lsearch_chk.sv
module lsearch_chk
  import lsearch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [4:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              accept_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              busy_i,
  input logic              done_i
);
  logic launch_write;
  assign launch_write = reg_we_i && (reg_addr_i == OFF_CTRL) && reg_wdata_i[0];

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i)); // R9

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !launch_write) |=> done_i); // R9

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_i); // R4

  AST_REQ_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R4

  AST_ADDR_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o, 2)) |-> (mem_addr_o == $past(mem_addr_o, 2) + 1'b1)); // R4

  AST_EMPTY_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && cnt_i == '0) |=> !mem_req_o); // R7

  AST_BUSY_LAUNCH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && launch_write) |-> !accept_i); // R8
endmodule

bind lsearch_accel lsearch_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .accept_i    (accept_w),
  .cnt_i       (cnt_w),
  .busy_i      (busy_w),
  .done_i      (done_w)
);

// File: tb/lsearch_accel_tb.sv
module lsearch_accel_tb;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MEM_N  = 256;
  localparam logic [31:0] FAIL   = 32'hFF;
  localparam logic [31:0] HIT    = 32'h0000BEEF;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] cnt;
    logic [31:0] key;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd10,  16'd50, HIT},
    '{16'd41,  16'd30, HIT},
    '{16'd0,   16'd8,  32'h1003},
    '{16'd100, 16'd5,  32'h1000},
    '{16'd5,   16'd1,  32'h1005},
    '{16'd5,   16'd1,  32'h1006},
    '{16'd20,  16'd40, HIT},
    '{16'd200, 16'd10, 32'h10D1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [4:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;

  logic [31:0] mem [MEM_N];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          n_req = 0;
  logic [15:0] req_log [64];

  always #5 clk = ~clk;

  lsearch_accel u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (n_req < 64) req_log[n_req] <= mem_addr;
      n_req <= n_req + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // waits until done reads 1; returns cycles since t0
  task automatic wait_done(input int t0, output int lat);
    logic [31:0] st;
    lat = -1;
    for (int k = 0; k < 400; k++) begin
      rd(5'h10, st);
      if (st[1]) begin lat = cyc - t0; break; end
      @(posedge clk); #1;
    end
  endtask

  // reference scan built from the requirements
  task automatic ref_scan(input vec_t v, output logic [31:0] res, output int lat, output int nrd);
    res = FAIL; lat = 2 * int'(v.cnt) + 1; nrd = int'(v.cnt);
    for (int i = 0; i < int'(v.cnt); i++) begin
      if (mem[(int'(v.base) + i) % MEM_N] == v.key) begin
        res = 32'(int'(v.base) + i); lat = 2 * i + 3; nrd = i + 1; break;
      end
    end
  endtask

  task automatic run(input vec_t v, input string tag);
    logic [31:0] res, eres, st;
    int lat, elat, enrd, t0;
    bit seq_ok;
    ref_scan(v, eres, elat, enrd);
    wr(5'h00, 32'(v.base));
    wr(5'h04, v.key);
    wr(5'h08, 32'(v.cnt));
    n_req = 0;
    wr(5'h0C, 32'h1);
    t0 = cyc;
    rd(5'h10, st);
    chk(st == 32'h1, {tag, " R3 busy after launch"}, st, 32'h1);
    wait_done(t0, lat);
    rd(5'h14, res);
    chk(res == eres, {tag, (eres == FAIL) ? " R6 fail code" : " R5 hit address"}, res, eres);
    chk(lat == elat, {tag, (eres == FAIL) ? " R6 latency" : " R5 latency"}, 32'(lat), 32'(elat));
    seq_ok = (n_req == enrd);
    for (int i = 0; i < enrd && i < 64; i++)
      if (req_log[i] != 16'(int'(v.base) + i)) seq_ok = 1'b0;
    chk(seq_ok, {tag, " R4 read sequence"}, 32'(n_req), 32'(enrd));
  endtask

  initial begin
    logic [31:0] d, st;
    int lat, t0;
    for (int a = 0; a < MEM_N; a++) mem[a] = 32'h1000 + 32'(a);
    mem[40] = HIT; mem[60] = HIT; mem[70] = HIT;

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, sampled during reset and just after release
    for (int o = 0; o < 6; o++) begin
      rd(5'(o * 4), d);
      chk(d == 0, "R1 register reset value", d, 0);
    end
    chk(mem_req == 1'b0, "R1 no request in reset", 32'(mem_req), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    rd(5'h10, st);
    chk(st == 0, "R1 status after reset", st, 0);

    // R2 readback
    wr(5'h00, 32'hABCD1234); rd(5'h00, d); chk(d == 32'h1234, "R2 base readback", d, 32'h1234);
    wr(5'h04, 32'hCAFEF00D); rd(5'h04, d); chk(d == 32'hCAFEF00D, "R2 key readback", d, 32'hCAFEF00D);
    wr(5'h08, 32'h00070042); rd(5'h08, d); chk(d == 32'h0042, "R2 count readback", d, 32'h0042);
    rd(5'h0C, d); chk(d == 0, "R2 control reads zero", d, 0);

    // table-driven searches
    for (int i = 0; i < NV; i++) run(VECS[i], $sformatf("vec%0d", i));

    // R7 empty dataset
    run('{16'd3, 16'd0, 32'h1003}, "empty R7");

    // R9 done persists, then clears on launch
    repeat (5) @(posedge clk);
    #1 rd(5'h10, st);
    chk(st == 32'h2, "R9 done holds while idle", st, 32'h2);
    wr(5'h08, 32'd4);
    wr(5'h0C, 32'h1);
    rd(5'h10, st);
    chk(st[1] == 1'b0, "R9 done cleared on launch", st, 32'h1);
    wait_done(cyc, lat);

    // R8 launch while busy is ignored
    wr(5'h00, 32'd100); wr(5'h04, 32'h0); wr(5'h08, 32'd30);
    n_req = 0;
    wr(5'h0C, 32'h1);
    t0 = cyc;
    repeat (4) @(posedge clk);
    wr(5'h00, 32'd40); wr(5'h04, HIT); wr(5'h08, 32'd2);
    wr(5'h0C, 32'h1);
    wait_done(t0, lat);
    rd(5'h14, d);
    chk(d == FAIL, "R8 result of original search", d, FAIL);
    chk(lat == 61, "R8 original timing kept", 32'(lat), 61);
    chk(n_req == 30 && req_log[0] == 16'd100, "R8 original reads only", 32'(n_req), 30);
    repeat (6) @(posedge clk);
    #1 rd(5'h10, st);
    chk(st == 32'h2 && n_req == 30, "R8 no second search", st, 32'h2);

    // R10 mid-search writes do not disturb the running search
    wr(5'h00, 32'd10); wr(5'h04, HIT); wr(5'h08, 32'd50);
    wr(5'h0C, 32'h0);
    n_req = 0;
    wr(5'h0C, 32'h1);
    t0 = cyc;
    wr(5'h04, 32'h1005); wr(5'h00, 32'd0); wr(5'h08, 32'd1);
    wait_done(t0, lat);
    rd(5'h14, d);
    chk(d == 32'd40, "R10 captured key and base", d, 40);
    chk(lat == 63, "R10 captured count timing", 32'(lat), 63);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule